// File: doc/BRIEF.md
# Three-Domain Transfer Reset Sequencer

This block lives in the control clock domain of a three-stage transfer datapath. The three data domains are source, intermediate and destination, and each runs on its own clock. The block produces an active-low reset and an enable for each data domain. It uses one reset path both for bringing the datapath up after power-on and for cleaning up after an aborted transfer. Resetting the domains clears stale samples and metadata much faster than draining them one beat per cycle.

When an abort arrives, the block keeps the enables high until the datapath reports that every outstanding bus transaction has finished. It then asserts reset in all three domains. Each domain counts its own clock cycles while its synchronized reset is active and reports back once the count is met; release waits until every domain has reported. Release runs against the data flow. The destination domain is released first, then the intermediate domain, then the source domain. Each step waits until the control domain sees the previous domain's reset go inactive. A one-cycle flag marks arrival in the ready state. A pause only lowers the enables, so the domains keep their state and continue on resume.

Domain index 0 is source, 1 is intermediate and 2 is destination in every per-domain vector.

Top module: `xfer_rst_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until init_i is pulsed, dom_rst_no is 3'b000, dom_en_o is 3'b000 and shutdown_o is 0. In that state go_i, pause_i, resume_i and abort_i change none of the outputs.
- R2: init_i starts an assert-and-release sequence from any state. It takes priority over abort and pause, so the sequence completes without idle_i ever being raised.
- R3: Every domain's reset stays low for at least HOLD_CYC (default 4) cycles of that domain's own clock. No domain is released until all three domains have reported that count.
- R4: Resets are released in the order bit 2 (destination), then bit 1, then bit 0 (source). A domain is released only after the control domain has seen the previous domain's reset go inactive.
- R5: shutdown_o is high for exactly one clk_i cycle when the ready state is entered. In the ready state all resets are high and all enables are low.
- R6: go_i in the ready state raises dom_en_o to 3'b111 with resets still high.
- R7: After abort_i in the running state, the enables stay high and no reset is asserted while idle_i is low. Once idle_i is high, all three resets are asserted and the release sequence follows.
- R8: pause_i while running drops dom_en_o to 3'b000 and leaves the resets high. resume_i raises dom_en_o to 3'b111 again.
- R9: abort_i while paused is honoured. It leads to the same wait for idle and the same reset sequence as an abort while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | control clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| dom_clk_i | input | 3 | data-domain clocks: 0 source, 1 intermediate, 2 destination |
| init_i | input | 1 | startup trigger pulse |
| go_i | input | 1 | start a transfer from the ready state |
| abort_i | input | 1 | abort the running or paused transfer |
| idle_i | input | 1 | datapath has no outstanding bus transactions |
| pause_i | input | 1 | pause the running transfer |
| resume_i | input | 1 | resume a paused transfer |
| dom_rst_no | output | 3 | per-domain active-low reset, synchronous to that domain's clock |
| dom_en_o | output | 3 | per-domain enable, synchronous to that domain's clock |
| shutdown_o | output | 1 | one-cycle pulse on entry to the ready state |

## Verification
The bench measures, in each domain's own clock, how long that domain's reset stays low. A design that released early, or that counted hold cycles in the fast control clock, would show fewer than HOLD_CYC cycles in the slow destination domain. Release times are timestamped per domain, so a design that released all domains together or in the forward direction fails the ordering checks. Aborts are held for long stretches without idle to catch a design that resets while transactions are pending. An abort is also issued during pause, and an init is issued on the same cycle as an abort with idle low. These catch designs that drop the abort while paused or that let the abort path override startup.

// File: rtl/xfer_rst_pkg.sv
package xfer_rst_pkg;
  localparam int NUM_DOM = 3;
  localparam int DOM_SRC = 0;
  localparam int DOM_MID = 1;
  localparam int DOM_DST = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RUN,
    ST_PAUSE,
    ST_WAIT_IDLE,
    ST_ASSERT,
    ST_REL_DST,
    ST_REL_MID,
    ST_REL_SRC,
    ST_SHUT
  } seq_state_e;
endpackage

// File: rtl/xfer_sync2.sv
module xfer_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/xfer_dom_port.sv
// Data-domain side: reset/enable synchronizers and hold-cycle counter.
module xfer_dom_port #(
  parameter int HOLD_CYC = 4
) (
  input  logic dom_clk_i,
  input  logic rst_ni,
  input  logic rst_req_i,
  input  logic en_req_i,
  output logic dom_rst_no,
  output logic dom_en_o,
  output logic rst_lvl_o,
  output logic held_o
);
  localparam int CW = $clog2(HOLD_CYC) + 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HOLD_CYC - 1);

  logic rst_sync, en_sync, held_q;
  logic [CW-1:0] cnt_q;

  xfer_sync2 #(.RST_VAL(1'b1)) u_rst_sync (
    .clk_i(dom_clk_i), .rst_ni(rst_ni), .d_i(rst_req_i), .q_o(rst_sync)
  );

  xfer_sync2 #(.RST_VAL(1'b0)) u_en_sync (
    .clk_i(dom_clk_i), .rst_ni(rst_ni), .d_i(en_req_i), .q_o(en_sync)
  );

  always_ff @(posedge dom_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (!rst_sync) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (cnt_q < CNT_TOP) cnt_q <= cnt_q + 1'b1;
      held_q <= (cnt_q >= CNT_TOP);
    end
  end

  assign dom_rst_no = ~rst_sync;
  assign dom_en_o   = en_sync & ~rst_sync;
  assign rst_lvl_o  = rst_sync;
  assign held_o     = held_q;
endmodule

// File: rtl/xfer_rst_fsm.sv
module xfer_rst_fsm
  import xfer_rst_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               go_i,
  input  logic               abort_i,
  input  logic               idle_i,
  input  logic               pause_i,
  input  logic               resume_i,
  input  logic [NUM_DOM-1:0] rst_fb_i,
  input  logic [NUM_DOM-1:0] held_fb_i,
  output logic [NUM_DOM-1:0] rst_req_o,
  output logic               en_req_o,
  output logic               shutdown_o,
  output seq_state_e         state_o
);
  seq_state_e state_q, state_nx;
  logic [NUM_DOM-1:0] rst_req_q, rst_req_nx;
  logic en_q, shut_q;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE:      state_nx = ST_IDLE;
      ST_SHUT:      if (go_i) state_nx = ST_RUN;
      ST_RUN: begin
        if (abort_i)      state_nx = ST_WAIT_IDLE;
        else if (pause_i) state_nx = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (abort_i)       state_nx = ST_WAIT_IDLE;
        else if (resume_i) state_nx = ST_RUN;
      end
      ST_WAIT_IDLE: if (idle_i) state_nx = ST_ASSERT;
      ST_ASSERT:  if ((&rst_fb_i) && (&held_fb_i)) state_nx = ST_REL_DST;
      ST_REL_DST: if (!rst_fb_i[DOM_DST]) state_nx = ST_REL_MID;
      ST_REL_MID: if (!rst_fb_i[DOM_MID]) state_nx = ST_REL_SRC;
      ST_REL_SRC: if (!rst_fb_i[DOM_SRC]) state_nx = ST_SHUT;
      default:    state_nx = ST_IDLE;
    endcase
    // startup wins over every pending request
    if (init_i) state_nx = ST_ASSERT;
  end

  always_comb begin
    rst_req_nx = '0;
    unique case (state_nx)
      ST_IDLE, ST_ASSERT: rst_req_nx = '1;
      ST_REL_DST: begin
        rst_req_nx[DOM_MID] = 1'b1;
        rst_req_nx[DOM_SRC] = 1'b1;
      end
      ST_REL_MID: rst_req_nx[DOM_SRC] = 1'b1;
      default:    rst_req_nx = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rst_req_q <= '1;
      en_q      <= 1'b0;
      shut_q    <= 1'b0;
    end else begin
      state_q   <= state_nx;
      rst_req_q <= rst_req_nx;
      en_q      <= (state_nx == ST_RUN) || (state_nx == ST_WAIT_IDLE);
      shut_q    <= (state_nx == ST_SHUT) && (state_q != ST_SHUT);
    end
  end

  assign rst_req_o  = rst_req_q;
  assign en_req_o   = en_q;
  assign shutdown_o = shut_q;
  assign state_o    = state_q;
endmodule

// File: rtl/xfer_rst_seq.sv
module xfer_rst_seq
  import xfer_rst_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DOM-1:0] dom_clk_i,
  input  logic               init_i,
  input  logic               go_i,
  input  logic               abort_i,
  input  logic               idle_i,
  input  logic               pause_i,
  input  logic               resume_i,
  output logic [NUM_DOM-1:0] dom_rst_no,
  output logic [NUM_DOM-1:0] dom_en_o,
  output logic               shutdown_o
);
  logic [NUM_DOM-1:0] rst_req, rst_fb, held_fb, rst_lvl, held_lvl;
  logic en_req;
  seq_state_e fsm_state;

  xfer_rst_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .init_i(init_i), .go_i(go_i), .abort_i(abort_i), .idle_i(idle_i),
    .pause_i(pause_i), .resume_i(resume_i),
    .rst_fb_i(rst_fb), .held_fb_i(held_fb),
    .rst_req_o(rst_req), .en_req_o(en_req),
    .shutdown_o(shutdown_o), .state_o(fsm_state)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    xfer_dom_port #(.HOLD_CYC(HOLD_CYC)) u_port (
      .dom_clk_i(dom_clk_i[d]), .rst_ni(rst_ni),
      .rst_req_i(rst_req[d]), .en_req_i(en_req),
      .dom_rst_no(dom_rst_no[d]), .dom_en_o(dom_en_o[d]),
      .rst_lvl_o(rst_lvl[d]), .held_o(held_lvl[d])
    );
    // feedback into control domain
    xfer_sync2 #(.RST_VAL(1'b1)) u_fb_rst (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_lvl[d]), .q_o(rst_fb[d])
    );
    xfer_sync2 #(.RST_VAL(1'b0)) u_fb_held (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(held_lvl[d]), .q_o(held_fb[d])
    );
  end
endmodule

// File: rtl/xfer_rst_seq_chk.sv
module xfer_rst_seq_chk
  import xfer_rst_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               init_i,
  input logic               idle_i,
  input logic               shutdown_o,
  input seq_state_e         state_i,
  input logic [NUM_DOM-1:0] rst_req_i,
  input logic [NUM_DOM-1:0] rst_fb_i,
  input logic [NUM_DOM-1:0] held_fb_i
);
  assert_shutdown_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !shutdown_o);

  assert_hold_before_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_i[DOM_DST]) |-> ($past(&held_fb_i) && $past(&rst_fb_i)));

  assert_mid_after_dst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_i[DOM_MID]) |-> (!rst_fb_i[DOM_DST] && !rst_req_i[DOM_DST]));

  assert_src_after_mid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_i[DOM_SRC]) |-> (!rst_fb_i[DOM_MID] && !rst_req_i[DOM_MID]));

  assert_no_reset_before_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT_IDLE && !idle_i && !init_i) |=> (rst_req_i == '0));
endmodule

bind xfer_rst_seq xfer_rst_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .idle_i(idle_i),
  .shutdown_o(shutdown_o), .state_i(fsm_state),
  .rst_req_i(rst_req), .rst_fb_i(rst_fb), .held_fb_i(held_fb)
);

// File: tb/xfer_rst_seq_tb.sv
`timescale 1ns/1ps
module xfer_rst_seq_tb;
  localparam int HOLD = 4;

  logic clk = 0, rst_ni = 0;
  logic [2:0] dom_clk = '0;
  logic init_i = 0, go_i = 0, abort_i = 0, idle_i = 0, pause_i = 0, resume_i = 0;
  logic [2:0] dom_rst_no, dom_en_o;
  logic shutdown_o;

  int errors = 0, checks = 0;
  int lowcnt [3];
  int hold_low [3];
  realtime rel_t [3];
  int pulses = 0, run_len = 0, max_run = 0;

  always #10 clk = ~clk;
  always #6  dom_clk[0] = ~dom_clk[0];
  always #4  dom_clk[1] = ~dom_clk[1];
  always #17 dom_clk[2] = ~dom_clk[2];

  xfer_rst_seq #(.HOLD_CYC(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dom_clk_i(dom_clk),
    .init_i(init_i), .go_i(go_i), .abort_i(abort_i), .idle_i(idle_i),
    .pause_i(pause_i), .resume_i(resume_i),
    .dom_rst_no(dom_rst_no), .dom_en_o(dom_en_o), .shutdown_o(shutdown_o)
  );

  for (genvar k = 0; k < 3; k++) begin : g_mon
    initial begin
      lowcnt[k] = 0; hold_low[k] = 0; rel_t[k] = 0;
    end
    always @(posedge dom_clk[k]) begin
      if (!dom_rst_no[k]) lowcnt[k]++;
      else if (lowcnt[k] != 0) begin
        hold_low[k] = lowcnt[k];
        rel_t[k] = $realtime;
        lowcnt[k] = 0;
      end
    end
  end

  always @(posedge clk) begin
    if (shutdown_o) begin
      pulses++; run_len++;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  function automatic bit order_ok(realtime t_dst, realtime t_mid, realtime t_src, realtime t0);
    return (t_dst > t0) && (t_dst < t_mid) && (t_mid < t_src);
  endfunction

  function automatic logic [2:0] exp_en(bit running);
    return running ? 3'b111 : 3'b000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  // waits for the ready state, then checks hold, order, pulse and outputs
  task automatic expect_seq(input string req, input realtime t0, input int base);
    int n = 0;
    while (pulses == base && n < 4000) begin cyc(1); n++; end
    cyc(4);
    chk(pulses == base + 1, "R5", {req, " one shutdown pulse"}, pulses - base, 1);
    chk(max_run == 1, "R5", {req, " pulse width"}, max_run, 1);
    for (int k = 0; k < 3; k++)
      chk(hold_low[k] >= HOLD, "R3", {req, " hold cycles"}, hold_low[k], HOLD);
    chk(order_ok(rel_t[2], rel_t[1], rel_t[0], t0), "R4", {req, " release order dst,mid,src"},
        {29'd0, rel_t[2] < rel_t[1], rel_t[1] < rel_t[0], rel_t[2] > t0}, 3'b111);
    chk(dom_rst_no == 3'b111, "R5", {req, " resets released"}, dom_rst_no, 3'b111);
    chk(dom_en_o == exp_en(0), "R5", {req, " enables low"}, dom_en_o, 0);
  endtask

  task automatic start_xfer();
    pulse(go_i); cyc(8);
    chk(dom_en_o == exp_en(1), "R6", "enables after go", dom_en_o, 3'b111);
    chk(dom_rst_no == 3'b111, "R6", "resets high while running", dom_rst_no, 3'b111);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    realtime t0;
    int base;
    void'($urandom(32'd4711));
    cyc(5);
    chk(dom_rst_no == 3'b000 && dom_en_o == 3'b000 && !shutdown_o, "R1", "in reset",
        {dom_rst_no, dom_en_o, 1'b0, shutdown_o}, 0);
    rst_ni = 1; cyc(20);
    chk(dom_rst_no == 3'b000, "R1", "resets held before init", dom_rst_no, 0);
    pulse(go_i); cyc(2); pulse(pause_i); cyc(2); pulse(resume_i); cyc(2); pulse(abort_i); cyc(20);
    chk(dom_rst_no == 3'b000 && dom_en_o == 3'b000 && pulses == 0, "R1", "controls ignored before init",
        {dom_rst_no, dom_en_o}, 0);

    // startup
    t0 = $realtime; base = pulses;
    pulse(init_i);
    expect_seq("R2 startup", t0, base);

    // pause / resume
    start_xfer();
    pulse(pause_i); cyc(8);
    chk(dom_en_o == exp_en(0), "R8", "enables dropped on pause", dom_en_o, 0);
    chk(dom_rst_no == 3'b111, "R8", "no reset on pause", dom_rst_no, 3'b111);
    pulse(resume_i); cyc(8);
    chk(dom_en_o == exp_en(1), "R8", "enables back on resume", dom_en_o, 3'b111);

    // abort waits for idle
    pulse(abort_i); cyc(60);
    chk(dom_rst_no == 3'b111, "R7", "no reset before idle", dom_rst_no, 3'b111);
    chk(dom_en_o == exp_en(1), "R7", "enables kept before idle", dom_en_o, 3'b111);
    t0 = $realtime; base = pulses;
    idle_i = 1;
    expect_seq("R7 abort", t0, base);
    idle_i = 0;

    // abort during pause
    start_xfer();
    pulse(pause_i); cyc(5);
    pulse(abort_i); cyc(40);
    chk(dom_rst_no == 3'b111, "R9", "paused abort waits idle", dom_rst_no, 3'b111);
    t0 = $realtime; base = pulses;
    idle_i = 1;
    expect_seq("R9 paused abort", t0, base);
    idle_i = 0;

    // init wins over abort with idle low
    start_xfer();
    abort_i = 1; init_i = 1; cyc(1); abort_i = 0; init_i = 0;
    t0 = $realtime - 20.0; base = pulses;
    expect_seq("R2 init over abort", t0, base);

    // random mix
    for (int it = 0; it < 8; it++) begin
      int nt;
      start_xfer();
      nt = $urandom_range(1, 4);
      for (int j = 0; j < nt; j++) begin
        cyc($urandom_range(1, 30));
        pulse(pause_i); cyc($urandom_range(3, 20));
        chk(dom_en_o == exp_en(0), "R8", "random pause", dom_en_o, 0);
        if (j != nt - 1 || $urandom_range(0, 1) == 0) begin
          pulse(resume_i); cyc(8);
          chk(dom_en_o == exp_en(1), "R8", "random resume", dom_en_o, 3'b111);
        end
      end
      pulse(abort_i); cyc($urandom_range(10, 80));
      chk(dom_rst_no == 3'b111, "R7", "random abort before idle", dom_rst_no, 3'b111);
      t0 = $realtime; base = pulses;
      idle_i = 1;
      expect_seq("R7 random abort", t0, base);
      idle_i = 0;
    end
    finish_run();
  end
endmodule